// File: doc/BRIEF.md
# Anchor-Delta Color Tile Compressor

This block packs one tile of render-target color into as few 32-byte memory bursts as it can. A tile is 64 pixels of 32 bits (four 8-bit channels), 256 bytes in all. The pixels arrive in raster order, one per cycle, under a valid/ready handshake. The first pixel becomes the anchor. Every later pixel is stored as four signed channel differences from the anchor, and one delta width, chosen as the narrowest that fits every difference, applies to the whole tile.

Once the tile is complete, the block shows a metadata code for one cycle. The code gives the number of 32-byte units minus one and a raw flag. From the next cycle it sends the payload as 256-bit beats, and it honours backpressure on them. When the packed form would fill eight units or more, the tile goes out unchanged as raw data. The best case is one unit, a ratio of 8:1.

Top module: `dcc_tile_compressor`

## Requirements
- R1: After synchronous reset, in_ready is 1 and out_valid and meta_valid are 0.
- R2: The block accepts exactly 64 pixels per tile. in_ready falls after the 64th accepted pixel and rises again only after the final output beat has been accepted.
- R3: meta_valid is high for exactly one cycle, in the cycle right after the 64th pixel is accepted. out_valid first rises in the cycle after that.
- R4: If every pixel equals the anchor, the width code is 0 (delta width 0 bits), meta_units_m1 is 0 and meta_raw is 0, so one beat is sent.
- R5: If the widest channel difference lies in [-2, 1], the width code is 1 (2-bit deltas), meta_units_m1 is 2 and meta_raw is 0.
- R6: If the widest channel difference lies in [-8, 7] and outside [-2, 1], the width code is 2 (4-bit deltas), meta_units_m1 is 4 and meta_raw is 0.
- R7: Any difference outside [-8, 7] makes the tile raw: meta_raw is 1, meta_units_m1 is 7, and beat k carries pixels 8k to 8k+7, with pixel p at bits [32*(p mod 8)+31 : 32*(p mod 8)].
- R8: A packed payload, taken as one vector with beat k at bits [256k+255 : 256k], holds the width code in bits [1:0], zeros in bits [3:2], and the anchor in bits [35:4]. The low W bits of the difference for pixel i (1..63), channel c (channel c is pixel bits [8c+7:8c]) start at bit 36 + ((i-1)*4 + c)*W, least significant bit first. All higher bits are zero.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged.
- R10: out_last is 1 only on the final beat, number meta_units_m1. After that beat is accepted, out_valid drops.
- R11: Differences are taken modulo 256 and read as signed 8-bit values, so 0xFF to 0x00 counts as +1 and 0x00 to 0xFE counts as -2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts a pixel |
| in_pixel | input | 32 | Pixel, channel c in bits [8c+7:8c] |
| meta_valid | output | 1 | Metadata valid (one-cycle pulse) |
| meta_units_m1 | output | 3 | Number of 32-byte units minus one |
| meta_raw | output | 1 | Tile stored uncompressed |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 256 | Payload beat |
| out_last | output | 1 | Final beat of the tile |

## Verification
The bench sends a flat tile and tiles whose widest difference sits on each side of the 2-bit and 4-bit limits (+1/-2, -3/+2, +7/-8, +8). These show whether the width choice and its unit count are right at every boundary. A tile that crosses the channel wrap point (0xFF next to 0x00) shows whether differences are taken modulo 256 rather than as magnitudes. Random tiles and random stalls on the input and output check the raw beat order and how the handshake behaves under backpressure.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    localparam int PIX_W      = 32;
    localparam int CH_W       = 8;
    localparam int NUM_CH     = PIX_W / CH_W;
    localparam int TILE_PIX   = 64;
    localparam int BEAT_W     = 256;
    localparam int HDR_W      = 4;
    localparam int TILE_BITS  = TILE_PIX * PIX_W;
    localparam int NUM_BEATS  = TILE_BITS / BEAT_W;
    localparam int PIX_IDX_W  = $clog2(TILE_PIX);
    localparam int BEAT_IDX_W = $clog2(NUM_BEATS);

    typedef enum logic [1:0] {
        WCODE_ZERO = 2'd0,
        WCODE_TWO  = 2'd1,
        WCODE_FOUR = 2'd2,
        WCODE_RAW  = 2'd3
    } wcode_e;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_META  = 2'd1,
        ST_DRAIN = 2'd2
    } state_e;

    typedef struct packed {
        logic                  raw;
        logic [BEAT_IDX_W-1:0] units_m1;
    } meta_t;

    function automatic int code_bits(input wcode_e code);
        case (code)
            WCODE_ZERO: return 0;
            WCODE_TWO:  return 2;
            WCODE_FOUR: return 4;
            default:    return CH_W;
        endcase
    endfunction

    // Narrowest class that holds one two's-complement channel difference.
    function automatic wcode_e chan_class(input logic [CH_W-1:0] d);
        if (d == '0)
            return WCODE_ZERO;
        else if ((&d[CH_W-1:1]) || !(|d[CH_W-1:1]))
            return WCODE_TWO;
        else if ((&d[CH_W-1:3]) || !(|d[CH_W-1:3]))
            return WCODE_FOUR;
        else
            return WCODE_RAW;
    endfunction

    function automatic wcode_e wmax(input wcode_e a, input wcode_e b);
        return (a > b) ? a : b;
    endfunction

    // Size in whole bursts; fall back to raw when packing saves nothing.
    function automatic meta_t meta_of(input wcode_e code);
        meta_t m;
        int bits;
        int units;
        bits  = HDR_W + PIX_W + (TILE_PIX - 1) * NUM_CH * code_bits(code);
        units = (bits + BEAT_W - 1) / BEAT_W;
        if (code == WCODE_RAW || units >= NUM_BEATS) begin
            m.raw      = 1'b1;
            m.units_m1 = BEAT_IDX_W'(NUM_BEATS - 1);
        end else begin
            m.raw      = 1'b0;
            m.units_m1 = BEAT_IDX_W'(units - 1);
        end
        return m;
    endfunction

endpackage

// File: rtl/dcc_delta_classifier.sv
module dcc_delta_classifier
    import dcc_pkg::*;
(
    input  logic [PIX_W-1:0] pixel,
    input  logic [PIX_W-1:0] anchor,
    input  logic             is_anchor,
    output wcode_e           pix_code
);
    wcode_e ch_code [NUM_CH];

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
            logic [CH_W-1:0] diff;
            assign diff        = pixel[gc*CH_W +: CH_W] - anchor[gc*CH_W +: CH_W];
            assign ch_code[gc] = chan_class(diff);
        end
    endgenerate

    always_comb begin
        pix_code = WCODE_ZERO;
        if (!is_anchor) begin
            for (int c = 0; c < NUM_CH; c++)
                pix_code = wmax(pix_code, ch_code[c]);
        end
    end

endmodule

// File: rtl/dcc_payload_packer.sv
module dcc_payload_packer
    import dcc_pkg::*;
(
    input  logic [TILE_BITS-1:0] tile,
    input  wcode_e               code,
    output logic [TILE_BITS-1:0] payload
);
    localparam int NUM_VAR = 3;

    logic [TILE_BITS-1:0] variant [NUM_VAR];
    logic [PIX_W-1:0]     anchor;

    assign anchor = tile[PIX_W-1:0];

    always_comb begin
        variant[0]                     = '0;
        variant[0][HDR_W-1:0]          = HDR_W'(WCODE_ZERO);
        variant[0][HDR_W +: PIX_W]     = anchor;
    end

    genvar gv;
    generate
        for (gv = 1; gv < NUM_VAR; gv++) begin : g_var
            localparam int W = 2 << (gv - 1);
            always_comb begin
                logic [CH_W-1:0] d;
                int              off;
                variant[gv]                 = '0;
                variant[gv][HDR_W-1:0]      = HDR_W'(gv);
                variant[gv][HDR_W +: PIX_W] = anchor;
                for (int i = 1; i < TILE_PIX; i++) begin
                    for (int c = 0; c < NUM_CH; c++) begin
                        d   = tile[i*PIX_W + c*CH_W +: CH_W] - anchor[c*CH_W +: CH_W];
                        off = HDR_W + PIX_W + ((i - 1) * NUM_CH + c) * W;
                        variant[gv][off +: W] = d[W-1:0];
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        case (code)
            WCODE_ZERO: payload = variant[0];
            WCODE_TWO:  payload = variant[1];
            WCODE_FOUR: payload = variant[2];
            default:    payload = tile;
        endcase
    end

endmodule

// File: rtl/dcc_tile_compressor.sv
module dcc_tile_compressor
    import dcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_pixel,
    output logic              meta_valid,
    output logic [BEAT_IDX_W-1:0] meta_units_m1,
    output logic              meta_raw,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BEAT_W-1:0] out_data,
    output logic              out_last
);
    state_e                 state;
    logic [PIX_IDX_W-1:0]   pix_cnt;
    logic [BEAT_IDX_W-1:0]  beat_cnt;
    wcode_e                 tile_code;
    wcode_e                 pix_code;
    logic [TILE_BITS-1:0]   tile_buf;
    logic [TILE_BITS-1:0]   payload;
    meta_t                  meta;
    logic                   in_fire;

    assign in_ready = (state == ST_FILL);
    assign in_fire  = in_valid && in_ready;

    dcc_delta_classifier u_class (
        .pixel     (in_pixel),
        .anchor    (tile_buf[PIX_W-1:0]),
        .is_anchor (pix_cnt == '0),
        .pix_code  (pix_code)
    );

    dcc_payload_packer u_pack (
        .tile    (tile_buf),
        .code    (tile_code),
        .payload (payload)
    );

    always_ff @(posedge clk) begin
        if (in_fire)
            tile_buf[pix_cnt*PIX_W +: PIX_W] <= in_pixel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_FILL;
            pix_cnt   <= '0;
            beat_cnt  <= '0;
            tile_code <= WCODE_ZERO;
        end else begin
            case (state)
                ST_FILL: begin
                    if (in_fire) begin
                        tile_code <= (pix_cnt == '0) ? WCODE_ZERO : wmax(tile_code, pix_code);
                        pix_cnt   <= pix_cnt + 1'b1;
                        if (pix_cnt == PIX_IDX_W'(TILE_PIX - 1))
                            state <= ST_META;
                    end
                end
                ST_META: begin
                    beat_cnt <= '0;
                    state    <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (out_ready) begin
                        if (out_last) begin
                            beat_cnt <= '0;
                            state    <= ST_FILL;
                        end else begin
                            beat_cnt <= beat_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_FILL;
            endcase
        end
    end

    assign meta          = meta_of(tile_code);
    assign meta_valid    = (state == ST_META);
    assign meta_units_m1 = meta.units_m1;
    assign meta_raw      = meta.raw;
    assign out_valid     = (state == ST_DRAIN);
    assign out_data      = payload[beat_cnt*BEAT_W +: BEAT_W];
    assign out_last      = (beat_cnt == meta.units_m1);

endmodule

// File: rtl/dcc_tile_compressor_chk.sv
module dcc_tile_compressor_chk
    import dcc_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic [PIX_W-1:0]      in_pixel,
    input logic                  meta_valid,
    input logic [BEAT_IDX_W-1:0] meta_units_m1,
    input logic                  meta_raw,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [BEAT_W-1:0]     out_data,
    input logic                  out_last
);
    assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_meta_then_beats_R3: assert property (@(posedge clk) disable iff (rst)
        meta_valid |=> (out_valid && !meta_valid));

    assert_no_fill_while_draining_R2: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && (out_valid || meta_valid)));

    assert_last_ends_tile_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

    assert_raw_is_full_R7: assert property (@(posedge clk) disable iff (rst)
        (meta_valid && meta_raw) |-> (meta_units_m1 == BEAT_IDX_W'(NUM_BEATS - 1)));

    assert_input_stalls_on_meta_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(meta_valid) |-> $fell(in_ready));

endmodule

bind dcc_tile_compressor dcc_tile_compressor_chk u_chk (.*);

// File: tb/tb_dcc_tile_compressor.sv
module tb_dcc_tile_compressor;

    localparam int NT = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [31:0]  in_pixel;
    logic         meta_valid;
    logic [2:0]   meta_units_m1;
    logic         meta_raw;
    logic         out_valid;
    logic         out_ready;
    logic [255:0] out_data;
    logic         out_last;

    always #10 clk = ~clk;

    dcc_tile_compressor dut (.*);

    int nchecks = 0;
    int nerr    = 0;

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    string tags [NT] = '{"R4", "R5 R11", "R6", "R7", "R6", "R7", "R5", "R6"};

    function automatic logic [31:0] mkpix(input int t, input int i);
        logic [31:0] a;
        logic [31:0] p;
        int d;
        case (t)
            0: a = 32'h11223344;  1: a = 32'hFF00FF80;
            2: a = 32'h807F0108;  3: a = 32'h11223344;
            4: a = 32'h55555555;  6: a = 32'h01020304;
            7: a = 32'hA0A0A0A0;  default: a = $urandom;
        endcase
        if (t == 5) return $urandom;
        for (int c = 0; c < 4; c++) begin
            d = 0;
            if (i > 0) begin
                case (t)
                    1: d = ((i + c) % 4) - 2;
                    2: d = ((i * 3 + c) % 16) - 8;
                    3: d = (i == 40 && c == 2) ? 8 : 0;
                    4: d = (i == 63 && c == 0) ? -3 : 0;
                    6: d = (i == 10 && c == 3) ? -2 : 1;
                    7: d = (i == 5 && c == 1) ? 2 : ((i == 6 && c == 0) ? 7 : 0);
                    default: d = 0;
                endcase
            end
            p[c*8 +: 8] = 8'((int'(a[c*8 +: 8]) + d) & 255);
        end
        return p;
    endfunction

    logic [31:0]   mdl_px [64];
    logic [2047:0] exp_pay;
    int            exp_m1;
    bit            exp_raw;

    task automatic build_expect();
        int maxw = 0;
        int sd, need, units;
        logic [7:0] d;
        for (int i = 1; i < 64; i++)
            for (int c = 0; c < 4; c++) begin
                d  = mdl_px[i][c*8 +: 8] - mdl_px[0][c*8 +: 8];
                sd = (d >= 128) ? int'(d) - 256 : int'(d);
                if (sd == 0) need = 0;
                else if (sd >= -2 && sd <= 1) need = 2;
                else if (sd >= -8 && sd <= 7) need = 4;
                else need = 8;
                if (need > maxw) maxw = need;
            end
        units = (36 + 252 * maxw + 255) / 256;
        exp_pay = '0;
        if (units >= 8) begin
            exp_raw = 1'b1;
            exp_m1  = 7;
            for (int i = 0; i < 64; i++) exp_pay[i*32 +: 32] = mdl_px[i];
        end else begin
            exp_raw = 1'b0;
            exp_m1  = units - 1;
            exp_pay[3:0]  = (maxw == 0) ? 4'd0 : ((maxw == 2) ? 4'd1 : 4'd2);
            exp_pay[35:4] = mdl_px[0];
            for (int i = 1; i < 64; i++)
                for (int c = 0; c < 4; c++) begin
                    d = mdl_px[i][c*8 +: 8] - mdl_px[0][c*8 +: 8];
                    for (int b = 0; b < maxw; b++)
                        exp_pay[36 + ((i - 1) * 4 + c) * maxw + b] = d[b];
                end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R2: watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        logic [31:0] pq[$];
        int phase = 0, cnt = 0, beat = 0, tile = 0;
        bit prev_stall = 0, fire_in, fire_out;
        logic [255:0] prev_data = '0;
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < 64; i++) pq.push_back(mkpix(t, i));
        rst = 1'b1; in_valid = 1'b0; in_pixel = '0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(meta_valid == 1'b0, "R1 meta_valid", meta_valid, 0);
        while (tile < NT) begin
            chk(in_ready == (phase == 0), "R2 in_ready", in_ready, (phase == 0));
            chk(meta_valid == (phase == 1), "R3 meta_valid", meta_valid, (phase == 1));
            chk(out_valid == (phase == 2), "R10 out_valid", out_valid, (phase == 2));
            if (phase == 1) begin
                chk(meta_units_m1 == 3'(exp_m1), {tags[tile], " units"}, meta_units_m1, exp_m1);
                chk(meta_raw == exp_raw, {tags[tile], " raw flag"}, meta_raw, exp_raw);
            end
            if (phase == 2) begin
                chk(out_data == exp_pay[beat*256 +: 256], exp_raw ? "R7 beat" : "R8 beat",
                    out_data, exp_pay[beat*256 +: 256]);
                chk(out_last == (beat == exp_m1), "R10 out_last", out_last, (beat == exp_m1));
            end
            if (prev_stall)
                chk(out_valid && out_data == prev_data, "R9 stall hold", out_data, prev_data);
            in_valid  = (pq.size() > 0) && ($urandom % 10 < 7);
            in_pixel  = (pq.size() > 0) ? pq[0] : 32'h0;
            out_ready = ($urandom % 2) == 1;
            fire_in   = in_valid && in_ready;
            fire_out  = out_valid && out_ready;
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            case (phase)
                0: if (fire_in) begin
                    mdl_px[cnt] = pq.pop_front();
                    cnt++;
                    if (cnt == 64) begin
                        cnt = 0;
                        build_expect();
                        phase = 1;
                    end
                end
                1: begin phase = 2; beat = 0; end
                default: if (fire_out) begin
                    beat++;
                    if (beat > exp_m1) begin phase = 0; tile++; end
                end
            endcase
            @(negedge clk);
        end
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule